// File: doc/BRIEF.md
# Debug command sequencer

This block drives the command layer of a two-wire target debug port. A client hands it one command byte and up to three argument bytes. The block looks up the command, then asks the byte transceiver below it to send the command byte and the argument bytes. It then asks for the reply bytes that the command defines. When the last reply byte arrives, the block returns the reply and raises a one-cycle done strobe. Bit timing on the wire belongs to the transceiver, so this block only deals in whole bytes.

The supported commands are:
- chip erase
- configuration write and read
- status read
- chip ID read
- program-counter read
- halt, resume and single step
- instruction injection

For instruction injection, the low two bits of the command byte give the instruction length in bytes. The block sends exactly that many argument bytes and then reads back one byte, the accumulator. A command byte that is malformed or unknown is answered at once with an error. No port activity happens in that case.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and xfer_req_o are all low.
- R2: An accepted, valid command sends the command byte first and unchanged. It then sends its argument bytes in the order req_arg_i[7:0], [15:8], [23:16]. The number of argument bytes depends on the command:
  - 0x1D (configuration write) sends one.
  - 0x55, 0x56 and 0x57 (injection of 1, 2 or 3 bytes) send one, two and three.
  - Every other valid command sends none.
- R3: The number of reply bytes read depends on the command:
  - 0x68 (chip ID) and 0x28 (program counter) read two.
  - 0x14, 0x1D, 0x24, 0x3F, 0x44, 0x4C, 0x5C and 0x55 to 0x57 read one.
- R4: The layout of rsp_data_o depends on the reply length:
  - For a two-byte reply, the first byte received sits in rsp_data_o[15:8] and the second in [7:0].
  - For a one-byte reply, the byte sits in [7:0] and [15:8] is zero.
- R5: For a valid command, the behaviour at the end of the command is:
  - done_o is high for exactly one cycle, in the cycle after the transceiver acknowledges the last reply byte.
  - err_o is low.
  - busy_o is low in that same cycle.
- R6: Command byte 0x54 (injection with a length of zero) gives done_o with err_o high in the cycle after acceptance. No transceiver request is made.
- R7: Any command byte not listed in R2 and R3 gives done_o with err_o high in the cycle after acceptance. No transceiver request is made, and rsp_data_o reads zero.
- R8: While busy_o is high, req_valid_i is ignored. No extra byte is sent and no extra done_o occurs.
- R9: A transceiver request holds xfer_req_o, xfer_wr_o and xfer_data_o steady until xfer_ack_i. xfer_wr_o is high for every sent byte and low for every read. All sends come before any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command request, taken when busy_o is low |
| req_cmd_i | input | 8 | Command byte |
| req_arg_i | input | 24 | Argument bytes, lowest byte sent first |
| busy_o | output | 1 | A command is in flight |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Rejected command, valid with done_o |
| rsp_data_o | output | 16 | Reply bytes, first byte in the upper lane when two are read |
| xfer_req_o | output | 1 | Byte transfer request to the transceiver |
| xfer_wr_o | output | 1 | 1 = send xfer_data_o, 0 = read a byte |
| xfer_data_o | output | 8 | Byte to send |
| xfer_ack_i | input | 1 | Transceiver completed the requested byte |
| xfer_rdata_i | input | 8 | Byte read, valid with xfer_ack_i |

## Verification
The hardest case to reach from the ports is a new request that lands mid-command. It has to arrive while the sequencer is between a send and a read, and the bench must then show that it left no trace. The bench handles this by issuing a chip-ID read to a transceiver model that acknowledges every other cycle. Two cycles later it pulses a second request. It then compares the complete logged byte stream, the read count and the number of done strobes against a single chip-ID transaction. The full sweep of all 256 command bytes covers the length table and both rejection paths, because the model counts every byte the port is asked to move.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ARG_MAX = 3;
  localparam int unsigned RSP_MAX = 2;
  localparam int unsigned IDX_W   = $clog2(ARG_MAX + 1);
  localparam int unsigned ARG_W   = ARG_MAX * BYTE_W;
  localparam int unsigned RSP_W   = RSP_MAX * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_ERASE  = 8'h14;
  localparam logic [BYTE_W-1:0] OP_CFG_WR = 8'h1D;
  localparam logic [BYTE_W-1:0] OP_CFG_RD = 8'h24;
  localparam logic [BYTE_W-1:0] OP_STATUS = 8'h3F;
  localparam logic [BYTE_W-1:0] OP_HALT   = 8'h44;
  localparam logic [BYTE_W-1:0] OP_RESUME = 8'h4C;
  localparam logic [BYTE_W-1:0] OP_STEP   = 8'h5C;
  localparam logic [BYTE_W-1:0] OP_ID     = 8'h68;
  localparam logic [BYTE_W-1:0] OP_PC     = 8'h28;
  localparam logic [BYTE_W-1:0] OP_INJECT = 8'h54;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] n_arg;
    logic [IDX_W-1:0] n_rsp;
  } cmd_info_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RECV} seq_state_e;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_seq_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  output cmd_info_t         info_o
);
  always_comb begin
    info_o = '0;
    if (cmd_i[BYTE_W-1:2] == OP_INJECT[BYTE_W-1:2]) begin
      // length lives in the command byte; zero is malformed
      info_o.ok    = (cmd_i[1:0] != 2'd0);
      info_o.n_arg = IDX_W'(cmd_i[1:0]);
      info_o.n_rsp = IDX_W'(1);
    end else begin
      case (cmd_i)
        OP_CFG_WR: begin info_o.ok = 1'b1; info_o.n_arg = IDX_W'(1); info_o.n_rsp = IDX_W'(1); end
        OP_ID, OP_PC: begin info_o.ok = 1'b1; info_o.n_rsp = IDX_W'(2); end
        OP_ERASE, OP_CFG_RD, OP_STATUS, OP_HALT, OP_RESUME, OP_STEP:
          begin info_o.ok = 1'b1; info_o.n_rsp = IDX_W'(1); end
        default: info_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_rsp_shift.sv
module dbg_rsp_shift #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BYTES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    shift_i,
  input  logic [BYTE_W-1:0]       din_i,
  output logic [BYTES*BYTE_W-1:0] dout_o
);
  logic [BYTES-1:0][BYTE_W-1:0] lane_q;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q[g] <= '0;
      else if (clr_i)   lane_q[g] <= '0;
      else if (shift_i) begin
        if (g == 0) lane_q[g] <= din_i;
        else        lane_q[g] <= lane_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign dout_o = lane_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (dout_o == '0)); // R7
endmodule

// File: rtl/dbg_xfer_fsm.sv
module dbg_xfer_fsm
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BYTE_W-1:0] req_cmd_i,
  input  logic [ARG_W-1:0]  req_arg_i,
  input  cmd_info_t         info_i,
  input  logic              xfer_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              xfer_req_o,
  output logic              xfer_wr_o,
  output logic [BYTE_W-1:0] xfer_data_o,
  output logic              rsp_clr_o,
  output logic              rsp_shift_o
);
  seq_state_e                   state_q;
  logic [ARG_MAX:0][BYTE_W-1:0] tx_q;
  logic [IDX_W-1:0]             idx_q, n_arg_q, n_rsp_q;
  logic                         done_q, err_q;
  logic                         accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      idx_q   <= '0;
      n_arg_q <= '0;
      n_rsp_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          tx_q    <= {req_arg_i, req_cmd_i};
          n_arg_q <= info_i.n_arg;
          n_rsp_q <= info_i.n_rsp;
          idx_q   <= '0;
          err_q   <= !info_i.ok;
          if (info_i.ok) state_q <= ST_SEND;
          else           done_q  <= 1'b1;
        end
        ST_SEND: if (xfer_ack_i) begin
          if (idx_q == n_arg_q) begin
            idx_q <= '0;
            if (n_rsp_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else state_q <= ST_RECV;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_RECV: if (xfer_ack_i) begin
          if (idx_q == n_rsp_q - 1'b1) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else idx_q <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = done_q & err_q;
  assign xfer_req_o  = busy_o;
  assign xfer_wr_o   = (state_q == ST_SEND);
  assign xfer_data_o = (state_q == ST_SEND) ? tx_q[idx_q] : '0;
  assign rsp_clr_o   = accept;
  assign rsp_shift_o = (state_q == ST_RECV) && xfer_ack_i;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_ack_i |=> xfer_req_o && $stable(xfer_wr_o) && $stable(xfer_data_o)); // R9
  AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_wr_o |=> !(xfer_req_o && xfer_wr_o) || $past(done_o) || !$past(busy_o)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !xfer_req_o); // R6
  AST_ERR_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> !$past(xfer_req_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> $past(xfer_ack_i) && !$past(xfer_wr_o)); // R5
  AST_BUSY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(tx_q)); // R8
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BYTE_W-1:0] req_cmd_i,
  input  logic [ARG_W-1:0]  req_arg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [RSP_W-1:0]  rsp_data_o,
  output logic              xfer_req_o,
  output logic              xfer_wr_o,
  output logic [BYTE_W-1:0] xfer_data_o,
  input  logic              xfer_ack_i,
  input  logic [BYTE_W-1:0] xfer_rdata_i
);
  cmd_info_t info;
  logic      rsp_clr, rsp_shift;

  dbg_cmd_decode u_decode (
    .cmd_i  (req_cmd_i),
    .info_o (info)
  );

  dbg_xfer_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_cmd_i   (req_cmd_i),
    .req_arg_i   (req_arg_i),
    .info_i      (info),
    .xfer_ack_i  (xfer_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .xfer_req_o  (xfer_req_o),
    .xfer_wr_o   (xfer_wr_o),
    .xfer_data_o (xfer_data_o),
    .rsp_clr_o   (rsp_clr),
    .rsp_shift_o (rsp_shift)
  );

  dbg_rsp_shift #(.BYTE_W(BYTE_W), .BYTES(RSP_MAX)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rsp_clr),
    .shift_i (rsp_shift),
    .din_i   (xfer_rdata_i),
    .dout_o  (rsp_data_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> !busy_o && !done_o && !xfer_req_o); // R1
endmodule

// File: tb/dbg_cmd_seq_tb.sv
module dbg_cmd_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_cmd_i = '0;
  logic [23:0] req_arg_i = '0;
  logic        busy_o, done_o, err_o, xfer_req_o, xfer_wr_o;
  logic [15:0] rsp_data_o;
  logic [7:0]  xfer_data_o;
  logic        xfer_ack_i;
  logic [7:0]  xfer_rdata_i;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  dbg_cmd_seq u_dut (.*);

  // transceiver model: acks every other cycle, logs traffic
  logic       log_clr = 1'b0;
  logic [7:0] cur_cmd = '0;
  logic [7:0] sent_log [8];
  int         sent_n, rd_n;
  logic       wr_after_rd;

  function automatic logic [7:0] rd_val(logic [7:0] c, int k);
    return 8'h3C ^ (8'(k) * 8'h5B) ^ c;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_ack_i <= 1'b0; xfer_rdata_i <= '0;
      sent_n <= 0; rd_n <= 0; wr_after_rd <= 1'b0;
    end else if (log_clr) begin
      xfer_ack_i <= 1'b0; sent_n <= 0; rd_n <= 0; wr_after_rd <= 1'b0;
    end else if (xfer_req_o && !xfer_ack_i) begin
      xfer_ack_i <= 1'b1;
      if (xfer_wr_o) begin
        if (sent_n < 8) sent_log[sent_n] <= xfer_data_o;
        sent_n <= sent_n + 1;
        if (rd_n != 0) wr_after_rd <= 1'b1;
      end else begin
        xfer_rdata_i <= rd_val(cur_cmd, rd_n);
        rd_n <= rd_n + 1;
      end
    end else xfer_ack_i <= 1'b0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_info(input logic [7:0] c, output bit ok, output int na, output int nr);
    ok = 1; na = 0; nr = 1;
    if (c >= 8'h55 && c <= 8'h57) na = c - 8'h54;
    else if (c == 8'h1D) na = 1;
    else if (c == 8'h68 || c == 8'h28) nr = 2;
    else if (!(c inside {8'h14, 8'h24, 8'h3F, 8'h44, 8'h4C, 8'h5C})) begin ok = 0; nr = 0; end
  endtask

  task automatic issue(logic [7:0] c, logic [23:0] a);
    @(negedge clk_i); log_clr = 1'b1;
    @(negedge clk_i); log_clr = 1'b0;
    cur_cmd = c; req_cmd_i = c; req_arg_i = a; req_valid_i = 1'b1;
    @(negedge clk_i); req_valid_i = 1'b0;
  endtask

  task automatic wait_done(string req);
    int w = 0;
    while (!done_o && w < 200) begin @(negedge clk_i); w++; end
    check(req, 32'(done_o), 32'd1);
  endtask

  initial begin
    bit ok; int na, nr;
    logic [23:0] a;
    logic [15:0] er;
    repeat (3) @(negedge clk_i);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 done", 32'(done_o), 0);
    check("R1 err", 32'(err_o), 0);
    check("R1 xfer_req", 32'(xfer_req_o), 0);
    rst_ni = 1'b1;

    for (int c = 0; c < 256; c++) begin
      a = {8'(c) ^ 8'hA5, 8'(c) ^ 8'h5A, 8'(c) + 8'h11};
      exp_info(8'(c), ok, na, nr);
      issue(8'(c), a);
      wait_done(ok ? "R5 done" : (c == 8'h54 ? "R6 done" : "R7 done"));
      check(ok ? "R5 err" : (c == 8'h54 ? "R6 err" : "R7 err"), 32'(err_o), 32'(!ok));
      check(ok ? "R2 sent count" : (c == 8'h54 ? "R6 no port" : "R7 no port"),
            32'(sent_n), ok ? 32'(1 + na) : 0);
      check(ok ? "R3 read count" : "R7 no read", 32'(rd_n), 32'(nr));
      if (ok && sent_n == 1 + na) begin
        check("R2 cmd byte", 32'(sent_log[0]), 32'(c));
        for (int k = 0; k < na; k++) check("R2 arg byte", 32'(sent_log[k+1]), 32'(a[k*8 +: 8]));
      end
      if (nr == 2) er = {rd_val(8'(c), 0), rd_val(8'(c), 1)};
      else if (nr == 1) er = {8'h00, rd_val(8'(c), 0)};
      else er = '0;
      check(ok ? "R4 rsp" : "R7 rsp", 32'(rsp_data_o), 32'(er));
      if (ok) check("R9 order", 32'(wr_after_rd), 0);
      check("R5 busy low at done", 32'(busy_o), 0);
      @(negedge clk_i);
      check("R5 done one cycle", 32'(done_o), 0);
    end

    // R8: second request mid-command is ignored
    issue(8'h68, 24'h0);
    @(negedge clk_i);
    check("R8 busy during", 32'(busy_o), 1);
    req_cmd_i = 8'h14; req_valid_i = 1'b1;
    @(negedge clk_i); req_valid_i = 1'b0;
    wait_done("R8 done");
    check("R8 sent count", 32'(sent_n), 1);
    check("R8 cmd byte", 32'(sent_log[0]), 32'h68);
    check("R8 read count", 32'(rd_n), 2);
    check("R8 rsp", 32'(rsp_data_o), 32'({rd_val(8'h68, 0), rd_val(8'h68, 1)}));
    begin
      int extra = 0;
      for (int k = 0; k < 12; k++) begin @(negedge clk_i); if (done_o || xfer_req_o) extra++; end
      check("R8 no extra activity", 32'(extra), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule